// File: doc/BRIEF.md
# Programmable Interrupt Controller with Rotating Arbitration

This block gathers up to 64 interrupt inputs and presents them to a processor on two request lines. One is a normal interrupt and the other a fast interrupt. Each input has a one-byte control register. That byte sets whether the input is enabled, whether it is sensed as an active-high level, a rising edge or a falling edge, and which of the two request lines it drives. Edges are captured in sticky pending bits. Software clears them by writing ones to a status word. A level input is never latched: its status follows the pin, gated by its enable bit.

For each request line the controller picks one winner among the enabled requests routed to it. The winning source number appears on a port and in a readable vector register. By default the lowest-numbered request wins. When the rotation bit of the global control word is set, the arbitration becomes round-robin. Each read of a vector register counts as a grant, and the source just granted drops to the lowest priority for that line. The register interface is word addressed with byte enables, and read data is combinational from the address. Inputs are assumed to be synchronous to the clock already. NUM_SRC must be a multiple of 32 and no larger than 64.

Top module: `prio_intc`

## Requirements
- R1: After reset, every control byte, both global control words and every pending bit are 0. Both request outputs are low, and both vector registers (0x00 normal, 0x04 fast) read 0x80.
- R2: The control byte of source n is byte lane n%4 of the word at 0x40+4*(n/4). Only lanes with their byte enable set are written, and a read returns all four bytes. Byte fields: bit 3 is the enable, bits 5:4 select the trigger, bits 1:0 select the destination.
- R3: With trigger 0 (also 3), a source is level sensed. Its status bit equals input AND enable in the same cycle and never persists after the input drops.
- R4: Trigger 1 latches a pending bit on a low-to-high input change, and trigger 2 on a high-to-low change. The bit is set at the clock edge following the change, whatever the enable, and the opposite transition sets nothing.
- R5: Status for sources 0-31 reads at 0x80 and for sources 32-63 at 0x84, bit n%32. Writing 1 to a bit clears a latched edge; writing 0 leaves it unchanged.
- R6: When an edge event and a write-one clear of the same bit fall in the same cycle, the bit ends up set.
- R7: A source requests only when its status bit and its enable are both 1. Destination 1 drives fiq_o; destinations 0, 2 and 3 drive irq_o.
- R8: With rotation off, each line's winner is the lowest-numbered request routed to it. The vector register reads that number with bit 7 clear, or 0x80 when the line has no request. Reading a vector has no effect on the order.
- R9: Setting bit 6 of the word at 0x20 turns on rotation. After reset the search starts at source 0. A vector read while its line is active makes the source read the lowest priority, so the next higher-numbered request, wrapping around, wins next.
- R10: The words at 0x20 and 0x24 are read/write storage with per-byte enables.
- R11: Reprogramming an edge source to level sensing discards its latched event. Returning it to edge mode does not bring the event back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt inputs, synchronous to clk_i |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe, marks a vector read as a grant |
| bus_addr_i | input | 8 | Byte address, word aligned |
| bus_be_i | input | 4 | Byte enables for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| irq_id_o | output | $clog2(NUM_SRC) | Winning source on the normal line |
| fiq_id_o | output | $clog2(NUM_SRC) | Winning source on the fast line |

## Verification
The coincidence of interest is an edge arriving on a source in the same clock cycle as software's write-one acknowledge of that source's pending bit. The bench raises a rising-edge input and issues the clear on the same edge. It then requires the status bit to stay set. A later clear with no event must empty the bit. An assertion also requires that every event seen in one cycle is present in the pending vector in the next cycle.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_FALL  = 2'd2,
    TRIG_RSVD  = 2'd3
  } trig_e;

  typedef struct packed {
    logic [1:0] rsvd_hi;
    trig_e      trig;
    logic       en;
    logic       rsvd_lo;
    logic [1:0] dest;
  } src_ctrl_t;

  localparam logic [1:0] DEST_FAST = 2'd1;

  localparam logic [7:0] A_IRQ_VEC = 8'h00;
  localparam logic [7:0] A_FIQ_VEC = 8'h04;
  localparam logic [7:0] A_GCTL0   = 8'h20;
  localparam logic [7:0] A_GCTL1   = 8'h24;
  localparam logic [7:0] A_CTRL    = 8'h40;
  localparam logic [7:0] A_STAT    = 8'h80;

  localparam int ROT_BIT  = 6;
  localparam int NONE_BIT = 7;

endpackage

// File: rtl/prio_intc_src.sv
module prio_intc_src
  import prio_intc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       src_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       clr_i,
  output logic [7:0] ctrl_o,
  output logic       status_o,
  output logic       req_o,
  output logic       fast_o,
  output logic       edge_o,
  output logic       evt_o,
  output logic       pend_o
);

  src_ctrl_t ctrl_q;
  logic      prev_q;
  logic      pend_q;
  logic      pend_d;
  logic      is_edge;

  assign is_edge = (ctrl_q.trig == TRIG_RISE) || (ctrl_q.trig == TRIG_FALL);

  always_comb begin
    evt_o = 1'b0;
    if (ctrl_q.trig == TRIG_RISE) evt_o = src_i & ~prev_q;
    if (ctrl_q.trig == TRIG_FALL) evt_o = ~src_i & prev_q;
  end

  // a fresh event outranks a clear arriving in the same cycle
  always_comb begin
    if (!is_edge) pend_d = 1'b0;
    else          pend_d = (pend_q & ~clr_i) | evt_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= src_i;
      pend_q <= pend_d;
      if (wr_i) ctrl_q <= src_ctrl_t'(wdata_i);
    end
  end

  assign status_o = is_edge ? pend_q : (src_i & ctrl_q.en);
  assign req_o    = status_o & ctrl_q.en;
  assign fast_o   = (ctrl_q.dest == DEST_FAST);
  assign ctrl_o   = ctrl_q;
  assign edge_o   = is_edge;
  assign pend_o   = pend_q;

endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb #(
  parameter int N = 64,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic         rot_i,
  input  logic [W-1:0] last_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);

  logic [N-1:0] above;
  logic [N-1:0] pick;

  always_comb begin
    for (int i = 0; i < N; i++) above[i] = rot_i && (W'(i) > last_i);
    pick = ((req_i & above) != '0) ? (req_i & above) : req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pick[i]) idx_o = W'(i);
    end
  end

  assign valid_o = |req_i;

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_we_i,
  input  logic               bus_re_i,
  input  logic [7:0]         bus_addr_i,
  input  logic [3:0]         bus_be_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_o,
  output logic               fiq_o,
  output logic [ID_W-1:0]    irq_id_o,
  output logic [ID_W-1:0]    fiq_id_o
);

  localparam int NUM_DST = 2;

  logic [5:0]         wa;
  logic [31:0]        gctl0_q, gctl1_q;
  logic               rot_en;
  logic [7:0]         ctrl_all [NUM_SRC];
  logic [NUM_SRC-1:0] stat_all, req, fast, edge_m, evt, pend;
  logic [NUM_SRC-1:0] irq_req, fiq_req;
  logic [NUM_SRC-1:0] dst_req [NUM_DST];
  logic               arb_vld [NUM_DST];
  logic [ID_W-1:0]    arb_idx [NUM_DST];

  assign wa     = bus_addr_i[7:2];
  assign rot_en = gctl0_q[ROT_BIT];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int WI = g / 4;
    localparam int LN = g % 4;
    localparam int SW = g / 32;
    localparam int SB = g % 32;
    logic wr_hit, clr_hit;
    assign wr_hit  = bus_we_i && bus_be_i[LN] && (wa == 6'((A_CTRL >> 2) + WI));
    assign clr_hit = bus_we_i && bus_be_i[SB / 8] && bus_wdata_i[SB]
                     && (wa == 6'((A_STAT >> 2) + SW));
    prio_intc_src u_src (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_i[g]),
      .wr_i     (wr_hit),
      .wdata_i  (bus_wdata_i[8*LN +: 8]),
      .clr_i    (clr_hit),
      .ctrl_o   (ctrl_all[g]),
      .status_o (stat_all[g]),
      .req_o    (req[g]),
      .fast_o   (fast[g]),
      .edge_o   (edge_m[g]),
      .evt_o    (evt[g]),
      .pend_o   (pend[g])
    );
  end

  assign irq_req    = req & ~fast;
  assign fiq_req    = req & fast;
  assign dst_req[0] = irq_req;
  assign dst_req[1] = fiq_req;

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    logic [ID_W-1:0] last_q;
    logic            grant;
    assign grant = rot_en && bus_re_i && (wa == 6'(d)) && arb_vld[d];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    last_q <= '1;
      else if (grant) last_q <= arb_idx[d];
    end
    prio_intc_arb #(.N(NUM_SRC), .W(ID_W)) u_arb (
      .req_i   (dst_req[d]),
      .rot_i   (rot_en),
      .last_i  (last_q),
      .valid_o (arb_vld[d]),
      .idx_o   (arb_idx[d])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gctl0_q <= '0;
      gctl1_q <= '0;
    end else if (bus_we_i) begin
      for (int b = 0; b < 4; b++) begin
        if (bus_be_i[b] && wa == 6'(A_GCTL0 >> 2)) gctl0_q[8*b +: 8] <= bus_wdata_i[8*b +: 8];
        if (bus_be_i[b] && wa == 6'(A_GCTL1 >> 2)) gctl1_q[8*b +: 8] <= bus_wdata_i[8*b +: 8];
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (wa == 6'(A_IRQ_VEC >> 2) || wa == 6'(A_FIQ_VEC >> 2)) begin
      bus_rdata_o[ID_W-1:0] = arb_idx[wa[0]];
      bus_rdata_o[NONE_BIT] = ~arb_vld[wa[0]];
    end else if (wa == 6'(A_GCTL0 >> 2)) begin
      bus_rdata_o = gctl0_q;
    end else if (wa == 6'(A_GCTL1 >> 2)) begin
      bus_rdata_o = gctl1_q;
    end else if (wa[5:4] == 2'b01) begin
      for (int b = 0; b < 4; b++) begin
        if (int'(wa[3:0]) * 4 + b < NUM_SRC)
          bus_rdata_o[8*b +: 8] = ctrl_all[int'(wa[3:0]) * 4 + b];
      end
    end else if (wa[5:1] == 5'b10000) begin
      if (32 * int'(wa[0]) < NUM_SRC) bus_rdata_o = stat_all[32*wa[0] +: 32];
    end
  end

  assign irq_o    = arb_vld[0];
  assign fiq_o    = arb_vld[1];
  assign irq_id_o = arb_idx[0];
  assign fiq_id_o = arb_idx[1];

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int NUM_SRC = 64,
  parameter int ID_W = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [ID_W-1:0]    irq_id_o,
  input logic [ID_W-1:0]    fiq_id_o,
  input logic               rot_en,
  input logic [NUM_SRC-1:0] irq_req,
  input logic [NUM_SRC-1:0] fiq_req,
  input logic [NUM_SRC-1:0] evt,
  input logic [NUM_SRC-1:0] edge_m,
  input logic [NUM_SRC-1:0] pend
);

  logic [NUM_SRC-1:0] below_irq;
  assign below_irq = (NUM_SRC'(1) << irq_id_o) - NUM_SRC'(1);

  a_r7_irq_tracks_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (irq_req != '0));

  a_r7_irq_winner_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_req[irq_id_o]);

  a_r7_fiq_winner_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> fiq_req[fiq_id_o]);

  a_r8_fixed_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rot_en) |-> ((irq_req & below_irq) == '0));

  a_r6_event_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(evt) & ~pend) == '0));

  a_r11_level_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend & ~$past(edge_m)) == '0));

endmodule

bind prio_intc prio_intc_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .irq_id_o (irq_id_o),
  .fiq_id_o (fiq_id_o),
  .rot_en   (rot_en),
  .irq_req  (irq_req),
  .fiq_req  (fiq_req),
  .evt      (evt),
  .edge_m   (edge_m),
  .pend     (pend)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC = 64;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic               rst_ni;
  logic [NUM_SRC-1:0] src;
  logic               we, re;
  logic [7:0]         addr;
  logic [3:0]         be;
  logic [31:0]        wdata, rdata;
  logic               irq, fiq;
  logic [5:0]         irq_id, fiq_id;

  prio_intc #(.NUM_SRC(NUM_SRC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src),
    .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr), .bus_be_i(be),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq), .irq_id_o(irq_id), .fiq_id_o(fiq_id)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] b);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    we = 1'b0; be = 4'h0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_ack(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic wr_ctrl(int s, logic [7:0] v);
    wr(8'(8'h40 + (s / 4) * 4), 32'(v) << (8 * (s % 4)), 4'(1 << (s % 4)));
  endtask

  task automatic set_src(int s, logic v);
    @(negedge clk);
    src[s] = v;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); chk("R1 irq vector", d, 32'h80);
    rd(8'h04, d); chk("R1 fiq vector", d, 32'h80);
    rd(8'h40, d); chk("R1 ctrl bytes", d, 0);
    rd(8'h20, d); chk("R1 gctl0", d, 0);
    rd(8'h84, d); chk("R1 status hi", d, 0);
    chk("R1 outputs", {30'b0, irq, fiq}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h44, 32'h0A0B0C0D, 4'b0101);
    rd(8'h44, d); chk("R2 ctrl lanes", d, 32'h000B000D);
    wr(8'h44, 32'h0, 4'hF);
    wr(8'h24, 32'hDEADBEEF, 4'b1100);
    rd(8'h24, d); chk("R10 gctl1 lanes", d, 32'hDEAD0000);
    wr(8'h24, 32'h0, 4'hF);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr_ctrl(3, 8'h0B);
    @(negedge clk);
    src[3] = 1'b1; src[4] = 1'b1;
    #1;
    chk("R7 level irq (dest 3)", {26'b0, irq, fiq_o_l(), irq_id}, {26'b0, 1'b1, 1'b0, 6'd3});
    rd(8'h80, d); chk("R3 live status, disabled src4", d, 32'h8);
    rd(8'h00, d); chk("R8 vector", d, 32'd3);
    src[3] = 1'b0;
    #1 chk("R3 drop same cycle", {31'b0, irq}, 0);
    @(negedge clk);
    rd(8'h80, d); chk("R3 no sticky", d, 0);
    src[4] = 1'b0;
    wr_ctrl(3, 8'h00);
  endtask

  function automatic logic fiq_o_l();
    return fiq;
  endfunction

  task automatic t_rise;
    logic [31:0] d;
    wr_ctrl(40, 8'h10);
    set_src(40, 1'b1);
    @(negedge clk);
    rd(8'h84, d); chk("R4 rise latches while disabled", d, 32'h100);
    chk("R7 disabled no request", {31'b0, irq}, 0);
    set_src(40, 1'b0);
    wr_ctrl(40, 8'h18);
    chk("R7 enabled pending requests", {25'b0, irq, irq_id}, {25'b0, 1'b1, 6'd40});
    wr(8'h84, 32'h0, 4'hF);
    rd(8'h84, d); chk("R5 zero write keeps", d, 32'h100);
    wr(8'h84, 32'h100, 4'hF);
    rd(8'h84, d); chk("R5 one write clears", d, 0);
    chk("R5 irq drops", {31'b0, irq}, 0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    @(negedge clk);
    src[40] = 1'b1;
    we = 1'b1; addr = 8'h84; wdata = 32'h100; be = 4'hF;
    @(negedge clk);
    we = 1'b0; be = 4'h0;
    rd(8'h84, d); chk("R6 event beats clear", d, 32'h100);
    wr(8'h84, 32'h100, 4'hF);
    rd(8'h84, d); chk("R5 clear without event", d, 0);
    set_src(40, 1'b0);
    @(negedge clk);
    rd(8'h84, d); chk("R4 fall ignored in rise mode", d, 0);
  endtask

  task automatic t_mode;
    logic [31:0] d;
    set_src(40, 1'b1);
    set_src(40, 1'b0);
    @(negedge clk);
    rd(8'h84, d); chk("R11 pending before switch", d, 32'h100);
    wr_ctrl(40, 8'h08);
    rd(8'h84, d); chk("R11 level reads input", d, 0);
    wr_ctrl(40, 8'h18);
    rd(8'h84, d); chk("R11 event discarded", d, 0);
    chk("R11 no request", {31'b0, irq}, 0);
    wr_ctrl(40, 8'h00);
  endtask

  task automatic t_fall;
    logic [31:0] d;
    wr_ctrl(7, 8'h29);
    set_src(7, 1'b1);
    @(negedge clk);
    rd(8'h80, d); chk("R4 rise ignored in fall mode", d, 0);
    set_src(7, 1'b0);
    @(negedge clk);
    rd(8'h80, d); chk("R4 fall latches", d, 32'h80);
    chk("R7 fast routing", {24'b0, irq, fiq, fiq_id}, {24'b0, 1'b0, 1'b1, 6'd7});
    rd(8'h04, d); chk("R8 fast vector", d, 32'd7);
    rd(8'h00, d); chk("R8 idle normal vector", d, 32'h80);
    wr(8'h80, 32'h80, 4'b0001);
    chk("R5 fast cleared", {31'b0, fiq}, 0);
    wr_ctrl(7, 8'h00);
  endtask

  task automatic t_fixed;
    logic [31:0] d;
    wr_ctrl(2, 8'h08); wr_ctrl(5, 8'h08); wr_ctrl(9, 8'h08);
    @(negedge clk);
    src[2] = 1'b1; src[5] = 1'b1; src[9] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      rd_ack(8'h00, d); chk("R8 fixed lowest wins", d, 32'd2);
    end
    chk("R8 id port", {26'b0, irq_id}, 32'd2);
  endtask

  task automatic t_rot;
    logic [31:0] d;
    logic [5:0] seq [4] = '{6'd2, 6'd5, 6'd9, 6'd2};
    wr(8'h20, 32'h40, 4'b0001);
    for (int k = 0; k < 4; k++) begin
      rd_ack(8'h00, d); chk("R9 rotation order", d, 32'(seq[k]));
    end
    rd(8'h00, d); chk("R9 plain read no grant", d, 32'd5);
    @(negedge clk);
    rd(8'h00, d); chk("R9 still no grant", d, 32'd5);
    wr(8'h20, 32'h0, 4'hF);
    @(negedge clk);
    src[2] = 1'b0; src[5] = 1'b0; src[9] = 1'b0;
    wr_ctrl(2, 8'h00); wr_ctrl(5, 8'h00); wr_ctrl(9, 8'h00);
    chk("R7 all quiet", {30'b0, irq, fiq}, 0);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; src = '0; we = 1'b0; re = 1'b0;
    addr = '0; be = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level();
    t_rise();
    t_collide();
    t_mode();
    t_fall();
    t_fixed();
    t_rot();
    summary();
    $finish;
  end
endmodule